// File: doc/BRIEF.md
# Speculative Load Alias Table

This block lets a core move a load above earlier stores whose addresses are not yet known to differ. When a speculative load issues, the core records the load's address and its destination register number in a small table. Every store that follows is compared with all live records, and any record whose 8-byte block matches the store is given a sticky conflict flag. Stores never stall.

Later the core issues a check naming the same destination register. The table finds the record for that register and answers one cycle later. It reports a conflict if the flag is set, if a store in the same cycle matches, or if no record exists for that register. The core then runs its repair code when needed. The check always frees the record it reads.

The table is fully associative on the register number. A new load to a register that already has a record reuses that record. When no record is free, the oldest one is replaced, so a later check on the displaced register fails on the safe side. The memory access itself and the repair sequence are outside this block.

Top module: `ld_alias_table`

## Requirements
- R1: While reset is asserted, and after it is released, the table holds no records and `rsp_valid` is 0; a check on a register loaded before a reset reports a conflict.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `chk_valid` high, and 0 otherwise.
- R3: A check on a register whose record saw no matching store reports `rsp_conflict` = 0.
- R4: A store whose address bits [31:3] equal those of a live record sets that record's conflict flag; a store in a different 8-byte block leaves the record clean.
- R5: A check frees its record, so a second check on the same register reports a conflict.
- R6: A check on a register with no record reports a conflict.
- R7: A new load to a register that already has a record replaces its address and clears its flag; a store to the old address then has no effect on it, and the table never holds two records for one register.
- R8: With all 8 records live, a load to a new register replaces the record written longest ago (a reload counts as a new write). A check on the displaced register then reports a conflict and the other records are unaffected. When a record is free, no record is displaced.
- R9: A store and a load in the same cycle to the same block leave the new record clean, because the store is ordered first.
- R10: A store in the same cycle as a check, matching that check's record, makes the check report a conflict.
- R11: When a check and a load name the same register in one cycle, the check reports the old record's state and the new load's record stays live and clean.
- R12: Store address inputs are ignored while `st_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_valid | input | 1 | Speculative load record request |
| ld_reg | input | 6 | Destination register of the speculative load |
| ld_addr | input | 32 | Byte address of the speculative load |
| st_valid | input | 1 | Store probe valid |
| st_addr | input | 32 | Byte address of the store |
| chk_valid | input | 1 | Check request |
| chk_reg | input | 6 | Register named by the check |
| rsp_valid | output | 1 | Check response valid, one cycle after the request |
| rsp_conflict | output | 1 | 1 means the core must take the repair path |

## Verification
The properties assume that the request ports carry meaningful values only while their valid bits are high. They also assume that requests begin only after the internal reset has been released, which takes two clock edges after `rst_n` rises. The bench drives every request on the falling edge and waits three cycles after each reset release before the first request. It also mixes same-cycle loads, stores and checks only in the pairings named by R9, R10 and R11, so every expected response follows from a single fixed order: store, then check, then load.

// File: rtl/ld_alias_pkg.sv
package ld_alias_pkg;
  // Update chosen for one table record in a cycle, in priority order.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_FILL = 2'd1,
    ACT_DROP = 2'd2,
    ACT_FLAG = 2'd3
  } rec_act_e;
endpackage

// File: rtl/ld_alias_entry.sv
module ld_alias_entry
  import ld_alias_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int BLK_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [REG_W-1:0] ld_reg,
  input  logic [BLK_W-1:0] ld_blk,
  input  logic             st_valid,
  input  logic [BLK_W-1:0] st_blk,
  input  logic             chk_valid,
  input  logic [REG_W-1:0] chk_reg,
  output logic             live,
  output logic             flagged,
  output logic [REG_W-1:0] owner,
  output logic             ld_hit,
  output logic             chk_hit,
  output logic             st_hit
);
  logic             live_q, live_d;
  logic             flag_q, flag_d;
  logic [REG_W-1:0] reg_q, reg_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  rec_act_e         act;

  assign ld_hit  = live_q && (reg_q == ld_reg);
  assign chk_hit = live_q && (reg_q == chk_reg);
  assign st_hit  = live_q && st_valid && (blk_q == st_blk);

  always_comb begin
    if (fill_en)                  act = ACT_FILL;
    else if (chk_valid && chk_hit) act = ACT_DROP;
    else if (st_hit)              act = ACT_FLAG;
    else                          act = ACT_HOLD;
  end

  always_comb begin
    live_d = live_q;
    flag_d = flag_q;
    reg_d  = reg_q;
    blk_d  = blk_q;
    case (act)
      ACT_FILL: begin
        live_d = 1'b1;
        flag_d = 1'b0;
        reg_d  = ld_reg;
        blk_d  = ld_blk;
      end
      ACT_DROP: live_d = 1'b0;
      ACT_FLAG: flag_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      flag_q <= 1'b0;
      reg_q  <= '0;
      blk_q  <= '0;
    end else if (act != ACT_HOLD) begin
      live_q <= live_d;
      flag_q <= flag_d;
      reg_q  <= reg_d;
      blk_q  <= blk_d;
    end
  end

  assign live    = live_q;
  assign flagged = flag_q;
  assign owner   = reg_q;
endmodule

// File: rtl/ld_alias_victim.sv
module ld_alias_victim #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic [ENTRIES-1:0] ld_hit_vec,
  input  logic [ENTRIES-1:0] live_vec,
  output logic [ENTRIES-1:0] fill_vec
);
  // older_q[i][j] = 1 : record i was written before record j
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q, older_d;
  logic [ENTRIES-1:0] free_vec, oldest_vec;
  logic               free_found, old_found;

  always_comb begin
    free_vec   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!live_vec[i] && !free_found) begin
        free_vec[i] = 1'b1;
        free_found  = 1'b1;
      end
    end
  end

  always_comb begin
    oldest_vec = '0;
    old_found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic cand;
      cand = live_vec[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && live_vec[j] && !older_q[i][j]) cand = 1'b0;
      end
      if (cand && !old_found) begin
        oldest_vec[i] = 1'b1;
        old_found     = 1'b1;
      end
    end
  end

  always_comb begin
    if (!ld_valid)        fill_vec = '0;
    else if (|ld_hit_vec) fill_vec = ld_hit_vec;
    else if (free_found)  fill_vec = free_vec;
    else                  fill_vec = oldest_vec;
  end

  always_comb begin
    older_d = older_q;
    for (int k = 0; k < ENTRIES; k++) begin
      if (fill_vec[k]) begin
        for (int j = 0; j < ENTRIES; j++) begin
          older_d[k][j] = 1'b0;
          older_d[j][k] = (j != k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         older_q <= '0;
    else if (|fill_vec) older_q <= older_d;
  end
endmodule

// File: rtl/ld_alias_table.sv
module ld_alias_table #(
  parameter int ENTRIES  = 8,
  parameter int REG_W    = 6,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_conflict
);
  localparam int BLK_W = ADDR_W - GRAN_LSB;

  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [BLK_W-1:0] ld_blk, st_blk;
  logic             unused_low;
  assign ld_blk     = ld_addr[ADDR_W-1:GRAN_LSB];
  assign st_blk     = st_addr[ADDR_W-1:GRAN_LSB];
  assign unused_low = ^{ld_addr[GRAN_LSB-1:0], st_addr[GRAN_LSB-1:0]};

  logic [ENTRIES-1:0]            ent_valid, ent_conf, fill_vec;
  logic [ENTRIES-1:0]            ld_hit_vec, chk_hit_vec, st_hit_vec;
  logic [ENTRIES-1:0][REG_W-1:0] ent_reg;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rec
    ld_alias_entry #(.REG_W(REG_W), .BLK_W(BLK_W)) u_rec (
      .clk      (clk),
      .rst_n    (rst_q),
      .fill_en  (fill_vec[g]),
      .ld_reg   (ld_reg),
      .ld_blk   (ld_blk),
      .st_valid (st_valid),
      .st_blk   (st_blk),
      .chk_valid(chk_valid),
      .chk_reg  (chk_reg),
      .live     (ent_valid[g]),
      .flagged  (ent_conf[g]),
      .owner    (ent_reg[g]),
      .ld_hit   (ld_hit_vec[g]),
      .chk_hit  (chk_hit_vec[g]),
      .st_hit   (st_hit_vec[g])
    );
  end

  ld_alias_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_q),
    .ld_valid  (ld_valid),
    .ld_hit_vec(ld_hit_vec),
    .live_vec  (ent_valid),
    .fill_vec  (fill_vec)
  );

  logic rsp_conf_d;
  assign rsp_conf_d = !(|chk_hit_vec) || (|(chk_hit_vec & (ent_conf | st_hit_vec)));

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid    <= 1'b0;
      rsp_conflict <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      if (chk_valid) rsp_conflict <= rsp_conf_d;
    end
  end
endmodule

// File: rtl/ld_alias_table_chk.sv
module ld_alias_table_chk #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 6
) (
  input logic                            clk,
  input logic                            rst_q,
  input logic                            ld_valid,
  input logic [REG_W-1:0]                ld_reg,
  input logic                            chk_valid,
  input logic [REG_W-1:0]                chk_reg,
  input logic                            rsp_valid,
  input logic                            rsp_conflict,
  input logic [ENTRIES-1:0]              ent_valid,
  input logic [ENTRIES-1:0]              ent_conf,
  input logic [ENTRIES-1:0][REG_W-1:0]   ent_reg,
  input logic [ENTRIES-1:0]              chk_hit_vec,
  input logic [ENTRIES-1:0]              ld_hit_vec
);
  logic             prev_ld, prev_chk_clean;
  logic [REG_W-1:0] prev_ld_reg, prev_chk_reg;
  logic             ld_rec_clean, chk_rec_left;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prev_ld        <= 1'b0;
      prev_chk_clean <= 1'b0;
      prev_ld_reg    <= '0;
      prev_chk_reg   <= '0;
    end else begin
      prev_ld        <= ld_valid;
      prev_chk_clean <= chk_valid && !(ld_valid && ld_reg == chk_reg);
      prev_ld_reg    <= ld_reg;
      prev_chk_reg   <= chk_reg;
    end
  end

  always_comb begin
    ld_rec_clean = 1'b0;
    chk_rec_left = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_valid[i] && ent_reg[i] == prev_ld_reg && !ent_conf[i]) ld_rec_clean = 1'b1;
      if (ent_valid[i] && ent_reg[i] == prev_chk_reg) chk_rec_left = 1'b1;
    end
  end

  AST_RSP_AFTER_CHK: assert property (@(posedge clk) disable iff (!rst_q)
    chk_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !chk_valid |=> !rsp_valid); // R2
  AST_ONE_REC_PER_CHK: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(chk_hit_vec)); // R7
  AST_ONE_REC_PER_LD: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(ld_hit_vec)); // R7
  AST_MISS_FAILS: assert property (@(posedge clk) disable iff (!rst_q)
    (chk_valid && chk_hit_vec == '0) |=> rsp_conflict); // R6
  AST_CHK_FREES: assert property (@(posedge clk) disable iff (!rst_q)
    prev_chk_clean |-> !chk_rec_left); // R5
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_q)
    prev_ld |-> ld_rec_clean); // R9
endmodule

bind ld_alias_table ld_alias_table_chk #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .ld_valid    (ld_valid),
  .ld_reg      (ld_reg),
  .chk_valid   (chk_valid),
  .chk_reg     (chk_reg),
  .rsp_valid   (rsp_valid),
  .rsp_conflict(rsp_conflict),
  .ent_valid   (ent_valid),
  .ent_conf    (ent_conf),
  .ent_reg     (ent_reg),
  .chk_hit_vec (chk_hit_vec),
  .ld_hit_vec  (ld_hit_vec)
);

// File: tb/test_ld_alias_table.sv
`timescale 1ns/1ps
module test_ld_alias_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, st_valid, chk_valid;
  logic [5:0]  ld_reg, chk_reg;
  logic [31:0] ld_addr, st_addr;
  logic        rsp_valid, rsp_conflict;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  ld_alias_table i_ld_alias_table (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_conflict(rsp_conflict)
  );

  // {ld_v, ld_reg, ld_addr, st_v, st_addr, chk_v, chk_reg, exp_conflict, req}
  localparam int VW = 84;
  localparam int NV = 24;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd5,  1'b1, 4'd6 },  // R6 empty table
    {1'b1, 6'd5,  32'h100, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd3 },
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd5,  1'b0, 4'd3 },  // R3 clean
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd5,  1'b1, 4'd5 },  // R5 freed
    {1'b1, 6'd7,  32'h200, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd4 },
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h207, 1'b0, 6'd0,  1'b0, 4'd4 },
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd7,  1'b1, 4'd4 },  // R4 same block
    {1'b1, 6'd8,  32'h300, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd4 },
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h308, 1'b0, 6'd0,  1'b0, 4'd4 },
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h300, 1'b0, 6'd0,  1'b0, 4'd12},
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd8,  1'b0, 4'd12},  // R4 R12
    {1'b1, 6'd9,  32'h400, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd7 },
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h400, 1'b0, 6'd0,  1'b0, 4'd7 },
    {1'b1, 6'd9,  32'h500, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd7 },
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h400, 1'b0, 6'd0,  1'b0, 4'd7 },
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd9,  1'b0, 4'd7 },  // R7 overwrite
    {1'b1, 6'd10, 32'h600, 1'b1, 32'h600, 1'b0, 6'd0,  1'b0, 4'd9 },
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd10, 1'b0, 4'd9 },  // R9 store first
    {1'b1, 6'd11, 32'h700, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd10},
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h700, 1'b1, 6'd11, 1'b1, 4'd10},  // R10
    {1'b1, 6'd12, 32'h800, 1'b0, 32'h0,   1'b0, 6'd0,  1'b0, 4'd11},
    {1'b0, 6'd0,  32'h0,   1'b1, 32'h800, 1'b0, 6'd0,  1'b0, 4'd11},
    {1'b1, 6'd12, 32'h900, 1'b0, 32'h0,   1'b1, 6'd12, 1'b1, 4'd11},  // R11 old state
    {1'b0, 6'd0,  32'h0,   1'b0, 32'h0,   1'b1, 6'd12, 1'b0, 4'd11}   // R11 new clean
  };

  task automatic check(input logic act, input logic exp, input int rq, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [5:0] lr, input logic [31:0] la,
                      input logic sv, input logic [31:0] sa,
                      input logic cv, input logic [5:0] cr, input logic ev, input int rq);
    @(negedge clk);
    ld_valid = lv; ld_reg = lr; ld_addr = la;
    st_valid = sv; st_addr = sa;
    chk_valid = cv; chk_reg = cr;
    @(posedge clk);
    #1;
    check(rsp_valid, cv, 2, "rsp_valid timing");  // R2
    if (cv) check(rsp_conflict, ev, rq, "rsp_conflict");
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rsp_valid, 1'b0, 1, "rsp_valid in reset");  // R1
    check(rsp_conflict, 1'b0, 1, "rsp_conflict in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid, 1'b0, 1, "rsp_valid after reset");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    ld_reg = '0; chk_reg = '0; ld_addr = '0; st_addr = '0;
    do_reset();

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      step(e[83], e[82:77], e[76:45], e[44], e[43:12], e[11], e[10:5], e[4], int'(e[3:0]));
    end

    // R8: fill all records, refresh r20, then displace the oldest (r21)
    for (int i = 0; i < 8; i++)
      step(1'b1, 6'(20 + i), 32'h1000 + 32'(i * 64), 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, 8);
    step(1'b1, 6'd20, 32'h2000, 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, 8);
    step(1'b1, 6'd30, 32'h3000, 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, 8);
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd21, 1'b1, 8);  // R8 displaced
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd20, 1'b0, 8);  // R8 refreshed kept
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd22, 1'b0, 8);
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd30, 1'b0, 8);
    step(1'b1, 6'd31, 32'h4000, 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, 8);
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd23, 1'b0, 8);  // R8 free slot used

    // R1: a record made before reset is gone afterwards
    step(1'b1, 6'd40, 32'h5000, 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, 1);
    do_reset();
    step(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd40, 1'b1, 1);  // R1 cleared

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule